// File: doc/BRIEF.md
# USB OUT Endpoint Status Logic

This block holds the control and status state of a single USB function OUT endpoint. A packet receiver reports one event per received data packet: which data PID it carried, whether a CRC or bit-stuff error was seen, and how many bytes arrived. The receiver also pulses a separate input when the OUT FIFO overflows. From these events and its own state, the block answers the host with ACK, STALL or no handshake. It also tells the FIFO side whether to keep or drop the packet, and it tracks the expected data toggle.

A CPU programs the endpoint through a two-word register port. Word 0 holds the flags and control bits. Word 1 holds a 10-bit maximum packet size. One control bit has two jobs. It selects isochronous operation, in which either data PID is accepted. It also holds the toggle at DATA0, so setting it and clearing it again during configuration restarts the toggle sequence. Flags that hardware raises are cleared by the CPU writing 0. Writing 1 to such a flag leaves it unchanged. An overrun interrupt request is raised when its enable bit is set.

Top module: `usb_out_ep_ctrl`

## Requirements
- R1: After reset, all word-0 bits read 0, the expected toggle is DATA0, word 1 reads the default size of 64, no handshake is issued and the interrupt is low.
- R2: In word 0, bit 0 is the interrupt enable, bit 1 is the isochronous/toggle-initialise bit, bit 2 is the software stall, bit 3 the overrun flag, bit 4 the data-error flag, bit 5 the forced-stall flag, and bit 6 reads back the expected toggle (0 = DATA0). Handshakes on `hs_code` are 0 none, 1 ACK, 2 STALL, and appear the cycle after `pkt_valid`. In non-isochronous mode, an error-free packet whose PID matches the expected toggle is ACKed and kept, and the toggle flips.
- R3: In non-isochronous mode, a packet whose PID does not match the expected toggle is ACKed but dropped, and the toggle does not change.
- R4: In isochronous mode, a packet with either PID is kept, gets no handshake, and leaves the toggle unchanged.
- R5: While bit 1 is 1, the expected toggle is held at DATA0. After the bit is cleared, the next packet expected is DATA0.
- R6: While the software stall bit is 1, every packet is answered with STALL and dropped, and the toggle does not change.
- R7: A packet whose byte count exceeds the maximum size sets the forced-stall flag and is answered with STALL. Later packets also get STALL until the CPU writes 0 to that flag. A byte count equal to the maximum is accepted.
- R8: In isochronous mode, a packet with a CRC or bit-stuff error sets the data-error flag. In non-isochronous mode, such a packet gets no handshake, is dropped, and sets no flag.
- R9: A FIFO overrun sets the overrun flag only in isochronous mode. In non-isochronous mode it is ignored.
- R10: `irq_ovr` is high exactly when the overrun flag and the interrupt enable are both 1.
- R11: Writing 1 to a hardware-set flag has no effect and writing 0 clears it. When a hardware set and a CPU clear land in the same cycle, the flag ends up set.
- R12: Word 1 bits 9:0 hold the maximum packet size. The CPU can write it and read it back, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | One-cycle pulse: a data packet has ended |
| pkt_pid_d1 | input | 1 | Packet PID: 1 = DATA1, 0 = DATA0 |
| pkt_rx_err | input | 1 | CRC or bit-stuff error in the packet |
| pkt_len | input | 11 | Received byte count |
| fifo_overrun | input | 1 | OUT FIFO overflow pulse |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_addr | input | 1 | Register word select |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Read data of the selected word |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 STALL |
| pkt_keep | output | 1 | Keep the packet in the FIFO |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
The handshake decision is driven with packet sequences that separate a matching PID from a repeated PID, and non-isochronous mode from isochronous mode. It is also driven with byte counts at the maximum size and one above it, which separates accepted packets from forced stalls. Error packets are sent in both modes to show that the data-error flag is raised only in isochronous mode. Overrun pulses are sent with the interrupt enable on and off, and one is aligned with a CPU write of 0, so that set-over-clear priority is observable. Toggling the isochronous bit and then sending DATA1 before DATA0 confirms that the toggle restarts at DATA0.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_STALL = 2'd2
  } hs_e;

  localparam int unsigned B_IEN  = 0;
  localparam int unsigned B_ISO  = 1;
  localparam int unsigned B_SSTL = 2;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_DERR = 4;
  localparam int unsigned B_FSTL = 5;
  localparam int unsigned B_TOG  = 6;

  typedef struct packed {
    hs_e  hs;
    logic keep;
    logic flip;
    logic set_fstl;
    logic set_derr;
  } verdict_t;
endpackage

// File: rtl/oep_pkt_judge.sv
module oep_pkt_judge
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned MAXP_W = 10,
  parameter int unsigned LEN_W  = 11
) (
  input  logic              pkt_valid,
  input  logic              pkt_pid_d1,
  input  logic              pkt_rx_err,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              iso,
  input  logic              sw_stall,
  input  logic              fstl,
  input  logic              tog,
  input  logic [MAXP_W-1:0] maxp,
  output verdict_t          verdict
);
  logic oversize;

  always_comb begin
    oversize = pkt_len > LEN_W'(maxp);
    verdict  = '0;
    verdict.hs = HS_NONE;
    if (pkt_valid) begin
      if (iso && pkt_rx_err) verdict.set_derr = 1'b1;
      if (!iso && pkt_rx_err) begin
        verdict.hs = HS_NONE;
      end else if (oversize) begin
        verdict.hs       = HS_STALL;
        verdict.set_fstl = 1'b1;
      end else if (sw_stall || fstl) begin
        verdict.hs = HS_STALL;
      end else if (iso) begin
        verdict.keep = 1'b1;
      end else begin
        verdict.hs = HS_ACK;
        if (pkt_pid_d1 == tog) begin
          verdict.keep = 1'b1;
          verdict.flip = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/oep_csr.sv
module oep_csr
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned MAXP_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MAXP_RST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_ovr,
  input  logic              set_derr,
  input  logic              set_fstl,
  input  logic              tog_flip,
  output logic              ien,
  output logic              iso,
  output logic              sw_stall,
  output logic              ovr,
  output logic              derr,
  output logic              fstl,
  output logic              tog,
  output logic [MAXP_W-1:0] maxp,
  output logic [DATA_W-1:0] rdata
);
  logic ien_d, iso_d, sstl_d, ovr_d, derr_d, fstl_d, tog_d;
  logic [MAXP_W-1:0] maxp_d;
  logic wr_ctl, wr_size;

  always_comb begin
    wr_ctl  = wr_en && !addr;
    wr_size = wr_en && addr;
    ien_d  = ien;
    iso_d  = iso;
    sstl_d = sw_stall;
    ovr_d  = ovr;
    derr_d = derr;
    fstl_d = fstl;
    maxp_d = maxp;
    if (wr_ctl) begin
      ien_d  = wdata[B_IEN];
      iso_d  = wdata[B_ISO];
      sstl_d = wdata[B_SSTL];
      ovr_d  = ovr  & wdata[B_OVR];
      derr_d = derr & wdata[B_DERR];
      fstl_d = fstl & wdata[B_FSTL];
    end
    if (set_ovr)  ovr_d  = 1'b1;
    if (set_derr) derr_d = 1'b1;
    if (set_fstl) fstl_d = 1'b1;
    if (wr_size)  maxp_d = wdata[MAXP_W-1:0];
    tog_d = iso ? 1'b0 : (tog ^ tog_flip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien      <= 1'b0;
      iso      <= 1'b0;
      sw_stall <= 1'b0;
      ovr      <= 1'b0;
      derr     <= 1'b0;
      fstl     <= 1'b0;
      tog      <= 1'b0;
    end else begin
      ien      <= ien_d;
      iso      <= iso_d;
      sw_stall <= sstl_d;
      ovr      <= ovr_d;
      derr     <= derr_d;
      fstl     <= fstl_d;
      tog      <= tog_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maxp <= MAXP_W'(MAXP_RST);
    end else if (wr_size) begin
      maxp <= maxp_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[B_IEN]  = ien;
      rdata[B_ISO]  = iso;
      rdata[B_SSTL] = sw_stall;
      rdata[B_OVR]  = ovr;
      rdata[B_DERR] = derr;
      rdata[B_FSTL] = fstl;
      rdata[B_TOG]  = tog;
    end else begin
      rdata[MAXP_W-1:0] = maxp;
    end
  end
endmodule

// File: rtl/usb_out_ep_ctrl.sv
module usb_out_ep_ctrl
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned MAXP_W   = 10,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MAXP_RST = 64,
  localparam int unsigned LEN_W   = MAXP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic              pkt_pid_d1,
  input  logic              pkt_rx_err,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              fifo_overrun,
  input  logic              cpu_wr_en,
  input  logic              cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [1:0]        hs_code,
  output logic              pkt_keep,
  output logic              irq_ovr
);
  logic ien_q, iso_q, sstl_q, ovr_q, derr_q, fstl_q, tog_q;
  logic [MAXP_W-1:0] maxp_q;
  verdict_t verdict;
  hs_e  hs_q;
  logic keep_q;

  oep_pkt_judge #(.MAXP_W(MAXP_W), .LEN_W(LEN_W)) u_judge (
    .pkt_valid (pkt_valid),
    .pkt_pid_d1(pkt_pid_d1),
    .pkt_rx_err(pkt_rx_err),
    .pkt_len   (pkt_len),
    .iso       (iso_q),
    .sw_stall  (sstl_q),
    .fstl      (fstl_q),
    .tog       (tog_q),
    .maxp      (maxp_q),
    .verdict   (verdict)
  );

  oep_csr #(.MAXP_W(MAXP_W), .DATA_W(DATA_W), .MAXP_RST(MAXP_RST)) u_csr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .addr    (cpu_addr),
    .wdata   (cpu_wdata),
    .set_ovr (fifo_overrun && iso_q),
    .set_derr(verdict.set_derr),
    .set_fstl(verdict.set_fstl),
    .tog_flip(verdict.flip),
    .ien     (ien_q),
    .iso     (iso_q),
    .sw_stall(sstl_q),
    .ovr     (ovr_q),
    .derr    (derr_q),
    .fstl    (fstl_q),
    .tog     (tog_q),
    .maxp    (maxp_q),
    .rdata   (cpu_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= HS_NONE;
      keep_q <= 1'b0;
    end else begin
      hs_q   <= verdict.hs;
      keep_q <= verdict.keep;
    end
  end

  assign hs_code  = hs_q;
  assign pkt_keep = keep_q;
  assign irq_ovr  = ovr_q & ien_q;
endmodule

// File: rtl/oep_checker.sv
module oep_checker #(
  parameter int unsigned MAXP_W = 10,
  parameter int unsigned LEN_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pkt_valid,
  input logic              pkt_rx_err,
  input logic [LEN_W-1:0]  pkt_len,
  input logic              fifo_overrun,
  input logic              cpu_wr_en,
  input logic [1:0]        hs_code,
  input logic              pkt_keep,
  input logic              irq_ovr,
  input logic              iso,
  input logic              tog,
  input logic [MAXP_W-1:0] maxp
);
  p_hs_follows_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code != 2'd0) |-> $past(pkt_valid));

  p_tog_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog) |-> ($past(pkt_valid) || $past(iso)));

  p_iso_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && iso) |=> (hs_code != 2'd1));

  p_tog_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iso |=> !tog);

  p_keep_not_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_keep |-> (hs_code != 2'd2));

  p_oversize_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (iso || !pkt_rx_err) && (pkt_len > LEN_W'(maxp)))
      |=> (hs_code == 2'd2 && !pkt_keep));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_ovr) |-> ($past(fifo_overrun) || $past(cpu_wr_en)));
endmodule

bind usb_out_ep_ctrl oep_checker #(.MAXP_W(MAXP_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pkt_valid   (pkt_valid),
  .pkt_rx_err  (pkt_rx_err),
  .pkt_len     (pkt_len),
  .fifo_overrun(fifo_overrun),
  .cpu_wr_en   (cpu_wr_en),
  .hs_code     (hs_code),
  .pkt_keep    (pkt_keep),
  .irq_ovr     (irq_ovr),
  .iso         (iso_q),
  .tog         (tog_q),
  .maxp        (maxp_q)
);

// File: tb/usb_out_ep_ctrl_bench.sv
`timescale 1ns/1ps
module usb_out_ep_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0, pkt_pid_d1 = 1'b0, pkt_rx_err = 1'b0;
  logic [10:0] pkt_len = '0;
  logic        fifo_overrun = 1'b0;
  logic        cpu_wr_en = 1'b0, cpu_addr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [1:0]  hs_code;
  logic        pkt_keep, irq_ovr;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference model state
  bit m_ien, m_iso, m_sstl, m_ovr, m_derr, m_fstl, m_tog, m_keep;
  int m_hs;
  int m_maxp;

  always #2 clk = ~clk;

  usb_out_ep_ctrl u_usb_out_ep_ctrl (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_pid_d1(pkt_pid_d1),
    .pkt_rx_err(pkt_rx_err), .pkt_len(pkt_len), .fifo_overrun(fifo_overrun),
    .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .hs_code(hs_code), .pkt_keep(pkt_keep), .irq_ovr(irq_ovr)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_rdata(bit a);
    if (a) return m_maxp;
    return int'(m_ien) | (int'(m_iso) << 1) | (int'(m_sstl) << 2) | (int'(m_ovr) << 3)
         | (int'(m_derr) << 4) | (int'(m_fstl) << 5) | (int'(m_tog) << 6);
  endfunction

  // behavioural model, advanced on each rising edge from the inputs held over it
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ien = 0; m_iso = 0; m_sstl = 0; m_ovr = 0; m_derr = 0; m_fstl = 0;
      m_tog = 0; m_keep = 0; m_hs = 0; m_maxp = 64;
    end else begin
      bit n_ien, n_iso, n_sstl, n_ovr, n_derr, n_fstl, n_tog, k, fl;
      int h;
      n_ien = m_ien; n_iso = m_iso; n_sstl = m_sstl;
      n_ovr = m_ovr; n_derr = m_derr; n_fstl = m_fstl;
      h = 0; k = 0; fl = 0;
      if (cpu_wr_en && !cpu_addr) begin
        n_ien = cpu_wdata[0]; n_iso = cpu_wdata[1]; n_sstl = cpu_wdata[2];
        if (!cpu_wdata[3]) n_ovr = 0;
        if (!cpu_wdata[4]) n_derr = 0;
        if (!cpu_wdata[5]) n_fstl = 0;
      end
      if (fifo_overrun && m_iso) n_ovr = 1;
      if (pkt_valid) begin
        if (m_iso && pkt_rx_err) n_derr = 1;
        if (pkt_rx_err && !m_iso) h = 0;
        else if (int'(pkt_len) > m_maxp) begin h = 2; n_fstl = 1; end
        else if (m_sstl || m_fstl) h = 2;
        else if (m_iso) k = 1;
        else begin
          h = 1;
          if (pkt_pid_d1 == m_tog) begin k = 1; fl = 1; end
        end
      end
      n_tog = m_iso ? 1'b0 : (m_tog ^ fl);
      if (cpu_wr_en && cpu_addr) m_maxp = int'(cpu_wdata[9:0]);
      m_ien = n_ien; m_iso = n_iso; m_sstl = n_sstl; m_ovr = n_ovr;
      m_derr = n_derr; m_fstl = n_fstl; m_tog = n_tog; m_hs = h; m_keep = k;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "hs_code", int'(hs_code), m_hs);
      chk(cur_req, "pkt_keep", int'(pkt_keep), int'(m_keep));
      chk(cur_req, "irq_ovr", int'(irq_ovr), int'(m_ien && m_ovr));
      chk(cur_req, "cpu_rdata", int'(cpu_rdata), exp_rdata(cpu_addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic idle();
    pkt_valid = 0; pkt_rx_err = 0; fifo_overrun = 0; cpu_wr_en = 0;
  endtask

  task automatic send(bit d1, bit err, int len);
    @(posedge clk); #1;
    idle();
    pkt_valid = 1; pkt_pid_d1 = d1; pkt_rx_err = err; pkt_len = 11'(len);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic wr(bit a, int d);
    @(posedge clk); #1;
    idle();
    cpu_wr_en = 1; cpu_addr = a; cpu_wdata = 16'(d);
    @(posedge clk); #1;
    idle();
  endtask

  task automatic look(bit a);
    @(posedge clk); #1;
    idle();
    cpu_addr = a;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1: reset values seen at the ports
    cur_req = "R1";
    cpu_addr = 0; #1;
    chk("R1", "word0 after reset", int'(cpu_rdata), 0);
    chk("R1", "hs after reset", int'(hs_code), 0);
    chk("R1", "irq after reset", int'(irq_ovr), 0);
    cpu_addr = 1; #1;
    chk("R1", "word1 after reset", int'(cpu_rdata), 64);
    step(1);

    cur_req = "R12";
    wr(1, 16'hFC08);
    look(1); step(1);
    chk("R12", "maxp readback", int'(cpu_rdata), 8);

    cur_req = "R2";
    look(0);
    send(0, 0, 4); send(1, 0, 8); step(1);
    chk("R2", "toggle after two good packets", int'(cpu_rdata[6]), 0);
    cur_req = "R3";
    send(1, 0, 4); step(1);
    chk("R3", "toggle after repeated PID", int'(cpu_rdata[6]), 0);
    send(0, 0, 2);

    cur_req = "R7";
    send(1, 0, 9); step(1);
    chk("R7", "forced stall flag", int'(cpu_rdata[5]), 1);
    send(1, 0, 1);
    cur_req = "R11";
    wr(0, 16'h0020); step(1);
    chk("R11", "write 1 keeps flag", int'(cpu_rdata[5]), 1);
    wr(0, 16'h0000); step(1);
    chk("R11", "write 0 clears flag", int'(cpu_rdata[5]), 0);

    cur_req = "R6";
    wr(0, 16'h0004); send(1, 0, 3); send(0, 0, 3);
    wr(0, 16'h0000);

    cur_req = "R8";
    send(1, 1, 3); step(1);
    chk("R8", "no data error outside iso", int'(cpu_rdata[4]), 0);

    cur_req = "R9";
    @(posedge clk); #1; fifo_overrun = 1; step(1); idle(); step(1);
    chk("R9", "overrun ignored outside iso", int'(cpu_rdata[3]), 0);

    cur_req = "R4";
    wr(0, 16'h0002); send(1, 0, 5); send(1, 0, 5); send(0, 0, 5);
    cur_req = "R8";
    send(0, 1, 5); step(1);
    chk("R8", "data error in iso", int'(cpu_rdata[4]), 1);
    cur_req = "R9";
    @(posedge clk); #1; fifo_overrun = 1; step(1); idle(); step(1);
    chk("R9", "overrun set in iso", int'(cpu_rdata[3]), 1);
    cur_req = "R10";
    wr(0, 16'h001B); step(1);
    chk("R10", "irq with enable", int'(irq_ovr), 1);
    cur_req = "R11";
    @(posedge clk); #1;
    cpu_wr_en = 1; cpu_addr = 0; cpu_wdata = 16'h0003; fifo_overrun = 1;
    step(1); idle(); step(1);
    chk("R11", "set beats clear", int'(cpu_rdata[3]), 1);
    cur_req = "R10";
    wr(0, 16'h0002); step(1);
    chk("R10", "irq low after clear", int'(irq_ovr), 0);

    cur_req = "R5";
    wr(0, 16'h0000); step(1);
    chk("R5", "toggle is DATA0 after init", int'(cpu_rdata[6]), 0);
    send(1, 0, 4); send(0, 0, 4); step(1);
    chk("R5", "toggle advanced from DATA0", int'(cpu_rdata[6]), 1);
    step(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule